// File: doc/BRIEF.md
# Single-channel memory-to-memory DMA engine with request pacing

The block moves data one beat at a time from a source address to a destination address over a simple request/acknowledge master port. Software programs four 32-bit registers (source address, destination address, remaining cycle count and control), then sets the enable bit. The engine runs the programmed number of transfer cycles. A cycle is one beat, or four beats in burst mode, and each beat is a read followed by a write of the data just read. Both addresses move after every beat by their own signed step.

Each side can be paced by a numbered request line. When a side names a nonzero line, every cycle waits for that request input, and the matching grant output pulses once the cycle is over. The cycle counter counts down live, so software can read how much work is left at any moment. Two sticky status flags, finish and error, can each be routed to a single interrupt output. An error input qualifies the acknowledge and stands in for a bus fault.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset all four registers read 0, `mst_req` is low, `irq` is low and every `dgnt` bit is low.
- R2: `reg_idx` selects the source address (0), destination address (1), cycle count (2, 24 bits, upper bits read 0) and control (3). A write to any index takes effect at the next clock edge and reads back unchanged, except where R5, R8 and R10 say otherwise. Control bits that are not defined read 0.
- R3: A cycle is 1 beat, or 4 beats when control bit 3 (burst) is 1. A beat reads the source address (`mst_we`=0) and then writes the data it read to the destination address (`mst_we`=1). `mst_size` carries control bits 21:20 (00 word, 01 halfword, 10 byte). `mst_sys` carries control bit 6 during reads and bit 7 during writes. While a request waits for `mst_ack`, its address and direction stay stable.
- R4: The source step code is control bits 10:8 and the destination step code is bits 14:12. Code 000 gives 0, 001/010/011 give +1/+2/+4, 101/110/111 give -1/-2/-4, and 100 gives 0. The step is added after every completed beat, so in burst mode the stride per cycle is four times the step.
- R5: The count register drops by exactly 1 when a cycle completes and can be read at any time. When the last cycle completes, the finish status (bit 1) is set and enable (bit 0) is cleared in the same clock edge.
- R6: Setting enable while the count is 0 sets finish and clears enable on the next edge, without any bus access.
- R7: The source request line number is bits 27:24 and the destination line number is bits 19:16, with 0 meaning no pacing. Before each cycle the engine waits until `dreq` is high on every nonzero line selected. In the clock after the cycle's last write is acknowledged, the matching `dgnt` bits pulse for one clock.
- R8: If `mst_err` is high together with `mst_ack`, the error status (bit 4) is set, enable is cleared and no further access is issued. The addresses and the count do not advance for that beat.
- R9: `irq` is high exactly when (finish AND bit 2) OR (error AND bit 5).
- R10: Writing control with a status bit at 0 clears that bit. Writing it at 1 leaves it unchanged and never sets it.
- R11: Clearing enable while a transfer runs stops the engine after the beat in progress. The count and the finish bit are left as they are, and no further access is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` (combinational) |
| mst_req | output | 1 | Bus access request |
| mst_we | output | 1 | 1 = write, 0 = read |
| mst_sys | output | 1 | Bus select of the current access (1 system bus, 0 peripheral bus) |
| mst_size | output | 2 | Access size code |
| mst_addr | output | 32 | Access address |
| mst_wdata | output | 32 | Write data |
| mst_ack | input | 1 | Access accepted or completed in this clock |
| mst_rdata | input | 32 | Read data, valid with `mst_ack` |
| mst_err | input | 1 | Access fault, qualified by `mst_ack` |
| dreq | input | 16 | Request lines, indexed by line number |
| dgnt | output | 16 | Grant pulses, indexed by line number |
| irq | output | 1 | Masked status interrupt |

## Verification
Every bus access is compared, on the clock it appears, against a queue of expected accesses built from the step codes. The runs use plain word copies and byte bursts with a decrementing destination, so per-beat and per-cycle stepping and the widths give different addresses. A halfword run where one side has a zero step separates the source and destination step logic. A paced run holds the request lines low, then releases them for exactly one cycle, which separates waiting from free running and shows the live count and one grant per cycle. The remaining runs are a zero-count enable, a read fault and an abort in mid-burst; each checks its own end state of the flags, the count and the addresses.

// File: rtl/dmae_pkg.sv
package dmae_pkg;

  localparam int REG_W = 32;

  localparam int B_EN    = 0;
  localparam int B_FIN   = 1;
  localparam int B_FIE   = 2;
  localparam int B_BURST = 3;
  localparam int B_ERR   = 4;
  localparam int B_EIE   = 5;
  localparam int B_SSEL  = 6;
  localparam int B_DSEL  = 7;
  localparam int SCODE_LSB = 8;
  localparam int DCODE_LSB = 12;
  localparam int DLINE_LSB = 16;
  localparam int WIDTH_LSB = 20;
  localparam int SLINE_LSB = 24;

  // plain writable control fields (status bits excluded)
  localparam logic [REG_W-1:0] CTRL_WMASK = 32'h0F3F_77ED;
  localparam logic [REG_W-1:0] CTRL_SMASK = 32'h0000_0012;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RD,
    ST_WR
  } seq_state_e;

  function automatic logic signed [3:0] step_of(input logic [2:0] code);
    case (code)
      3'b001:  step_of = 4'sd1;
      3'b010:  step_of = 4'sd2;
      3'b011:  step_of = 4'sd4;
      3'b101:  step_of = -4'sd1;
      3'b110:  step_of = -4'sd2;
      3'b111:  step_of = -4'sd4;
      default: step_of = 4'sd0;
    endcase
  endfunction

endpackage

// File: rtl/dmae_rst_sync.sv
module dmae_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/dmae_addr_gen.sv
module dmae_addr_gen import dmae_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              adv,
  input  logic [2:0]        code,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic signed [3:0] step;
  logic              addr_en;

  assign step    = step_of(code);
  assign addr_en = adv | load;

  always_comb begin
    addr_d = addr_q;
    if (adv)       addr_d = addr_q + {{(ADDR_W-4){step[3]}}, step};
    else if (load) addr_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr = addr_q;

  // R4: an advance moves the address by the decoded step
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> addr_q == $past(addr_q) + {{(ADDR_W-4){$past(step[3])}}, $past(step)});

endmodule

// File: rtl/dmae_regs.sv
module dmae_regs import dmae_pkg::*; #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cnt,
  input  logic             wr_ctrl,
  input  logic [REG_W-1:0] wdata,
  input  logic             cyc_done,
  input  logic             set_fin,
  input  logic             set_err,
  input  logic             clr_en,
  output logic [REG_W-1:0] ctrl,
  output logic [CNT_W-1:0] count
);

  logic [REG_W-1:0] ctrl_q, ctrl_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             ctrl_en, count_en;

  assign ctrl_en  = wr_ctrl | set_fin | set_err | clr_en;
  assign count_en = wr_cnt | cyc_done;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = (wdata & CTRL_WMASK) | (ctrl_q & wdata & CTRL_SMASK);
    if (set_fin) ctrl_d[B_FIN] = 1'b1;
    if (set_err) ctrl_d[B_ERR] = 1'b1;
    if (clr_en)  ctrl_d[B_EN]  = 1'b0;
  end

  always_comb begin
    count_d = count_q;
    if (cyc_done)    count_d = count_q - CNT_W'(1);
    else if (wr_cnt) count_d = wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  assign ctrl  = ctrl_q;
  assign count = count_q;

  // R5: without a software load the count only ever steps down by one
  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_cnt) && count_q != $past(count_q)) |-> count_q == $past(count_q) - CNT_W'(1));

  // R5: finish never rises with enable still set
  assert_fin_clears_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q[B_FIN]) |-> !ctrl_q[B_EN]);

  // R10: software alone never raises a status bit
  assert_no_sw_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(set_err) |-> !$rose(ctrl_q[B_ERR]));

endmodule

// File: rtl/dmae_seq.sv
module dmae_seq import dmae_pkg::*; #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LINE_W      = 4,
  parameter int BURST_BEATS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   burst,
  input  logic                   cnt_zero,
  input  logic                   cnt_one,
  input  logic [LINE_W-1:0]      src_line,
  input  logic [LINE_W-1:0]      dst_line,
  input  logic                   src_sel,
  input  logic                   dst_sel,
  input  logic [1:0]             width,
  input  logic [ADDR_W-1:0]      src_addr,
  input  logic [ADDR_W-1:0]      dst_addr,
  input  logic [(2**LINE_W)-1:0] dreq,
  input  logic                   mst_ack,
  input  logic [DATA_W-1:0]      mst_rdata,
  input  logic                   mst_err,
  output logic                   mst_req,
  output logic                   mst_we,
  output logic                   mst_sys,
  output logic [1:0]             mst_size,
  output logic [ADDR_W-1:0]      mst_addr,
  output logic [DATA_W-1:0]      mst_wdata,
  output logic [(2**LINE_W)-1:0] dgnt,
  output logic                   beat_adv,
  output logic                   cyc_done,
  output logic                   set_fin,
  output logic                   set_err,
  output logic                   clr_en
);

  localparam int NLINES = 2**LINE_W;
  localparam int BEAT_W = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;

  seq_state_e        state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d, last_beat;
  logic [DATA_W-1:0] data_q;
  logic [NLINES-1:0] gnt_q, gnt_d;
  logic              data_en, src_ok, dst_ok;

  assign last_beat = burst ? BEAT_W'(BURST_BEATS - 1) : '0;
  assign src_ok    = (src_line == '0) | dreq[src_line];
  assign dst_ok    = (dst_line == '0) | dreq[dst_line];
  assign data_en   = (state_q == ST_RD) & mst_ack & ~mst_err;

  always_comb begin
    state_d  = state_q;
    beat_d   = beat_q;
    gnt_d    = '0;
    beat_adv = 1'b0;
    cyc_done = 1'b0;
    set_fin  = 1'b0;
    set_err  = 1'b0;
    clr_en   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (en) begin
          if (cnt_zero) begin
            set_fin = 1'b1;
            clr_en  = 1'b1;
          end else begin
            state_d = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (!en) begin
          state_d = ST_IDLE;
        end else if (src_ok && dst_ok) begin
          state_d = ST_RD;
          beat_d  = '0;
        end
      end
      ST_RD: begin
        if (mst_ack) begin
          if (mst_err) begin
            set_err = 1'b1;
            clr_en  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_WR;
          end
        end
      end
      ST_WR: begin
        if (mst_ack) begin
          if (mst_err) begin
            set_err = 1'b1;
            clr_en  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            beat_adv = 1'b1;
            if (beat_q == last_beat) begin
              cyc_done = 1'b1;
              if (src_line != '0) gnt_d[src_line] = 1'b1;
              if (dst_line != '0) gnt_d[dst_line] = 1'b1;
              if (cnt_one) begin
                set_fin = 1'b1;
                clr_en  = 1'b1;
                state_d = ST_IDLE;
              end else begin
                state_d = ST_WAIT;
              end
            end else begin
              beat_d  = beat_q + BEAT_W'(1);
              state_d = en ? ST_RD : ST_IDLE;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      gnt_q   <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      gnt_q   <= gnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= mst_rdata;
  end

  assign mst_req   = (state_q == ST_RD) | (state_q == ST_WR);
  assign mst_we    = (state_q == ST_WR);
  assign mst_addr  = (state_q == ST_WR) ? dst_addr : src_addr;
  assign mst_sys   = (state_q == ST_WR) ? dst_sel : src_sel;
  assign mst_size  = width;
  assign mst_wdata = data_q;
  assign dgnt      = gnt_q;

  // R3: a pending request holds its address and direction
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_req && !mst_ack) |=> (mst_req && $stable(mst_addr) && $stable(mst_we)));

  // R8: a faulted access ends the transfer
  assert_err_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_req && mst_ack && mst_err) |=> !mst_req);

  // R7: grants are single-clock pulses
  assert_gnt_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|dgnt) |=> !(|dgnt));

  // R7: a paced source holds the cycle back until its request line is high
  assert_wait_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && src_line != '0 && !dreq[src_line]) |=> state_q != ST_RD);

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine import dmae_pkg::*; #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 24,
  parameter int LINE_W      = 4,
  parameter int BURST_BEATS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_we,
  input  logic [1:0]             reg_idx,
  input  logic [REG_W-1:0]       reg_wdata,
  output logic [REG_W-1:0]       reg_rdata,
  output logic                   mst_req,
  output logic                   mst_we,
  output logic                   mst_sys,
  output logic [1:0]             mst_size,
  output logic [ADDR_W-1:0]      mst_addr,
  output logic [DATA_W-1:0]      mst_wdata,
  input  logic                   mst_ack,
  input  logic [DATA_W-1:0]      mst_rdata,
  input  logic                   mst_err,
  input  logic [(2**LINE_W)-1:0] dreq,
  output logic [(2**LINE_W)-1:0] dgnt,
  output logic                   irq
);

  localparam int NSIDES = 2;

  logic             rst_i_n;
  logic [REG_W-1:0] ctrl;
  logic [CNT_W-1:0] count;
  logic             beat_adv, cyc_done, set_fin, set_err, clr_en;
  logic             wr_cnt, wr_ctrl;
  logic [ADDR_W-1:0] side_addr [NSIDES];
  logic              side_load [NSIDES];
  logic [2:0]        side_code [NSIDES];

  dmae_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  assign wr_cnt       = reg_we & (reg_idx == 2'd2);
  assign wr_ctrl      = reg_we & (reg_idx == 2'd3);
  assign side_load[0] = reg_we & (reg_idx == 2'd0);
  assign side_load[1] = reg_we & (reg_idx == 2'd1);
  assign side_code[0] = ctrl[SCODE_LSB +: 3];
  assign side_code[1] = ctrl[DCODE_LSB +: 3];

  dmae_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .wr_cnt   (wr_cnt),
    .wr_ctrl  (wr_ctrl),
    .wdata    (reg_wdata),
    .cyc_done (cyc_done),
    .set_fin  (set_fin),
    .set_err  (set_err),
    .clr_en   (clr_en),
    .ctrl     (ctrl),
    .count    (count)
  );

  for (genvar s = 0; s < NSIDES; s++) begin : g_side
    dmae_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .load     (side_load[s]),
      .load_val (reg_wdata[ADDR_W-1:0]),
      .adv      (beat_adv),
      .code     (side_code[s]),
      .addr     (side_addr[s])
    );
  end

  dmae_seq #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .LINE_W      (LINE_W),
    .BURST_BEATS (BURST_BEATS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .en        (ctrl[B_EN]),
    .burst     (ctrl[B_BURST]),
    .cnt_zero  (count == '0),
    .cnt_one   (count == CNT_W'(1)),
    .src_line  (ctrl[SLINE_LSB +: LINE_W]),
    .dst_line  (ctrl[DLINE_LSB +: LINE_W]),
    .src_sel   (ctrl[B_SSEL]),
    .dst_sel   (ctrl[B_DSEL]),
    .width     (ctrl[WIDTH_LSB +: 2]),
    .src_addr  (side_addr[0]),
    .dst_addr  (side_addr[1]),
    .dreq      (dreq),
    .mst_ack   (mst_ack),
    .mst_rdata (mst_rdata),
    .mst_err   (mst_err),
    .mst_req   (mst_req),
    .mst_we    (mst_we),
    .mst_sys   (mst_sys),
    .mst_size  (mst_size),
    .mst_addr  (mst_addr),
    .mst_wdata (mst_wdata),
    .dgnt      (dgnt),
    .beat_adv  (beat_adv),
    .cyc_done  (cyc_done),
    .set_fin   (set_fin),
    .set_err   (set_err),
    .clr_en    (clr_en)
  );

  always_comb begin
    case (reg_idx)
      2'd0:    reg_rdata = REG_W'(side_addr[0]);
      2'd1:    reg_rdata = REG_W'(side_addr[1]);
      2'd2:    reg_rdata = REG_W'(count);
      default: reg_rdata = ctrl;
    endcase
  end

  assign irq = (ctrl[B_FIN] & ctrl[B_FIE]) | (ctrl[B_ERR] & ctrl[B_EIE]);

  // R1: nothing is requested in the first clock out of reset
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_i_n)
    !$past(rst_i_n) |-> !mst_req);

endmodule

// File: tb/dma_chan_engine_tb.sv
module dma_chan_engine_tb;

  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [31:0] data;
    bit          sys;
  } acc_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_idx;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mst_req, mst_we, mst_sys, mst_ack, mst_err;
  logic [1:0]  mst_size;
  logic [31:0] mst_addr, mst_wdata, mst_rdata;
  logic [15:0] dreq, dgnt;
  logic        irq;

  int   checks = 0;
  int   errors = 0;
  int   wr_acks = 0;
  int   gnt_seen [16];
  bit   err_arm = 1'b0;
  bit   finished = 1'b0;
  logic [1:0]  exp_size = 2'b00;
  logic [31:0] fin_src, fin_dst, v;
  acc_t exp_q [$];

  always #4 clk = ~clk;

  dma_chan_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mst_req(mst_req),
    .mst_we(mst_we), .mst_sys(mst_sys), .mst_size(mst_size),
    .mst_addr(mst_addr), .mst_wdata(mst_wdata), .mst_ack(mst_ack),
    .mst_rdata(mst_rdata), .mst_err(mst_err), .dreq(dreq), .dgnt(dgnt),
    .irq(irq)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {~a[15:0], a[15:0]} ^ 32'h0F0F_0000;
  endfunction

  function automatic int step(input logic [2:0] c);
    case (c)
      3'b001: return 1;
      3'b010: return 2;
      3'b011: return 4;
      3'b101: return -1;
      3'b110: return -2;
      3'b111: return -4;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic predict(input logic [31:0] s0, input logic [31:0] d0, input logic [2:0] sc,
                         input logic [2:0] dc, input bit burst, input int cycles,
                         input int max_beats, input bit ssel, input bit dsel);
    logic [31:0] s, d;
    int beats;
    s = s0; d = d0;
    beats = cycles * (burst ? 4 : 1);
    if (max_beats >= 0 && max_beats < beats) beats = max_beats;
    for (int b = 0; b < beats; b++) begin
      exp_q.push_back('{1'b0, s, 32'h0, ssel});
      exp_q.push_back('{1'b1, d, pat(s), dsel});
      s = s + step(sc);
      d = d + step(dc);
    end
    fin_src = s;
    fin_dst = d;
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] data);
    @(negedge clk);
    reg_idx = idx; reg_wdata = data; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx, output logic [31:0] data);
    @(negedge clk);
    reg_idx = idx;
    #1 data = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    for (int i = 0; i < 500; i++) begin
      rd(2'd3, c);
      if (!c[0]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  // bus responder and per-clock reference comparison
  initial begin
    acc_t e;
    mst_ack = 1'b0; mst_err = 1'b0; mst_rdata = '0;
    forever begin
      @(negedge clk);
      for (int i = 0; i < 16; i++) if (dgnt[i]) gnt_seen[i]++;
      if (mst_ack) begin
        mst_ack = 1'b0; mst_err = 1'b0;
      end else if (rst_n && mst_req) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R3 unexpected access actual %h expected none", mst_addr);
        end else begin
          e = exp_q.pop_front();
          if (mst_addr !== e.addr) begin
            errors++;
            $display("FAIL R4 access address actual %h expected %h", mst_addr, e.addr);
          end else if (mst_we !== e.we || mst_sys !== e.sys || mst_size !== exp_size ||
                       (e.we && mst_wdata !== e.data)) begin
            errors++;
            $display("FAIL R3 access attrs actual %h/%b%b%b expected %h/%b%b%b",
                     mst_wdata, mst_we, mst_sys, mst_size, e.data, e.we, e.sys, exp_size);
          end
        end
        if (mst_we) wr_acks++;
        mst_rdata = pat(mst_addr);
        mst_err   = !mst_we && err_arm;
        if (!mst_we) err_arm = 1'b0;
        mst_ack   = 1'b1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) gnt_seen[i] = 0;
    rst_n = 1'b0; reg_we = 1'b0; reg_idx = 2'd0; reg_wdata = '0; dreq = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), v);
      chk(v == 0, "R1 register reset", v, 0);
    end
    chk(!irq && !mst_req && dgnt == 0, "R1 outputs idle", {irq, mst_req, dgnt}, 0);

    // T1: word copy, +4 steps, 3 cycles, finish interrupt enabled
    wr(2'd0, 32'h1000); wr(2'd1, 32'h2000); wr(2'd2, 32'h3);
    rd(2'd0, v); chk(v == 32'h1000, "R2 source readback", v, 32'h1000);
    rd(2'd2, v); chk(v == 32'h3, "R2 count readback", v, 32'h3);
    exp_size = 2'b00;
    predict(32'h1000, 32'h2000, 3'b011, 3'b011, 1'b0, 3, -1, 1'b1, 1'b0);
    wr(2'd3, 32'h0000_3345);
    wait_idle();
    chk(exp_q.size() == 0, "R3 all beats issued", exp_q.size(), 0);
    rd(2'd3, v); chk(v == 32'h3346, "R5 finish set enable cleared", v, 32'h3346);
    rd(2'd2, v); chk(v == 0, "R5 count reaches zero", v, 0);
    rd(2'd0, v); chk(v == fin_src, "R4 source final", v, fin_src);
    rd(2'd1, v); chk(v == fin_dst, "R4 destination final", v, fin_dst);
    chk(irq == 1'b1, "R9 finish interrupt", irq, 1);

    // T2: status write semantics
    wr(2'd3, 32'h3346);
    rd(2'd3, v); chk(v == 32'h3346, "R10 writing one keeps finish", v, 32'h3346);
    wr(2'd3, 32'h3344);
    rd(2'd3, v); chk(v == 32'h3344, "R10 writing zero clears finish", v, 32'h3344);
    chk(irq == 1'b0, "R9 irq drops with status", irq, 0);

    // T3: byte burst, source +1, destination -4, finish interrupt masked
    wr(2'd0, 32'h40); wr(2'd1, 32'h300); wr(2'd2, 32'h2);
    exp_size = 2'b10;
    predict(32'h40, 32'h300, 3'b001, 3'b111, 1'b1, 2, -1, 1'b0, 1'b1);
    wr(2'd3, 32'h0020_7189);
    wait_idle();
    chk(exp_q.size() == 0, "R3 burst issues four beats per cycle", exp_q.size(), 0);
    rd(2'd0, v); chk(v == 32'h48, "R4 burst source stride", v, 32'h48);
    rd(2'd1, v); chk(v == 32'h2E0, "R4 burst destination stride", v, 32'h2E0);
    rd(2'd3, v); chk(v == 32'h20718A, "R5 burst finish", v, 32'h20718A);
    chk(irq == 1'b0, "R9 masked finish", irq, 0);

    // T4: halfword, source fixed, destination -1
    wr(2'd3, 32'h0);
    wr(2'd0, 32'h500); wr(2'd1, 32'h600); wr(2'd2, 32'h2);
    exp_size = 2'b01;
    predict(32'h500, 32'h600, 3'b000, 3'b101, 1'b0, 2, -1, 1'b0, 1'b0);
    wr(2'd3, 32'h0010_5001);
    wait_idle();
    chk(exp_q.size() == 0, "R3 halfword beats", exp_q.size(), 0);
    rd(2'd0, v); chk(v == 32'h500, "R4 zero step holds source", v, 32'h500);
    rd(2'd1, v); chk(v == 32'h5FE, "R4 decrement destination", v, 32'h5FE);

    // T5: enable with zero count
    wr(2'd3, 32'h0);
    wr(2'd2, 32'h0);
    wr(2'd3, 32'h5);
    wait_idle();
    rd(2'd3, v); chk(v == 32'h6, "R6 zero count finishes at once", v, 32'h6);
    chk(irq == 1'b1, "R6 zero count interrupt", irq, 1);

    // T6: paced on source line 3 and destination line 5
    wr(2'd3, 32'h0);
    for (int i = 0; i < 16; i++) gnt_seen[i] = 0;
    wr(2'd0, 32'h800); wr(2'd1, 32'h900); wr(2'd2, 32'h2);
    exp_size = 2'b00;
    predict(32'h800, 32'h900, 3'b011, 3'b011, 1'b0, 2, -1, 1'b0, 1'b0);
    wr(2'd3, 32'h0305_3301);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 4, "R7 waits for request", exp_q.size(), 4);
    rd(2'd2, v); chk(v == 2, "R5 count live before start", v, 2);
    dreq = 16'h0028;
    for (int i = 0; i < 200; i++) begin
      rd(2'd2, v);
      if (v == 1) break;
    end
    dreq = 16'h0000;
    repeat (15) @(negedge clk);
    rd(2'd2, v); chk(v == 1, "R5 count live mid transfer", v, 1);
    chk(exp_q.size() == 2, "R7 stops when request drops", exp_q.size(), 2);
    chk(gnt_seen[3] == 1 && gnt_seen[5] == 1, "R7 one grant per cycle",
        {gnt_seen[3][15:0], gnt_seen[5][15:0]}, 32'h0001_0001);
    dreq = 16'h0028;
    wait_idle();
    dreq = 16'h0000;
    chk(gnt_seen[3] == 2 && gnt_seen[5] == 2, "R7 second grant",
        {gnt_seen[3][15:0], gnt_seen[5][15:0]}, 32'h0002_0002);
    begin
      int other = 0;
      for (int i = 0; i < 16; i++) if (i != 3 && i != 5) other += gnt_seen[i];
      chk(other == 0, "R7 no grant on other lines", other, 0);
    end
    chk(exp_q.size() == 0, "R7 paced transfer complete", exp_q.size(), 0);

    // T7: read fault
    wr(2'd3, 32'h0);
    wr(2'd0, 32'hA00); wr(2'd1, 32'hB00); wr(2'd2, 32'h4);
    exp_q.push_back('{1'b0, 32'hA00, 32'h0, 1'b0});
    err_arm = 1'b1;
    wr(2'd3, 32'h3321);
    wait_idle();
    chk(exp_q.size() == 0, "R8 single faulted read", exp_q.size(), 0);
    rd(2'd3, v); chk(v == 32'h3330, "R8 error set enable cleared", v, 32'h3330);
    rd(2'd2, v); chk(v == 4, "R8 count kept", v, 4);
    rd(2'd0, v); chk(v == 32'hA00, "R8 address not advanced", v, 32'hA00);
    chk(irq == 1'b1, "R9 error interrupt", irq, 1);

    // T8: abort in mid-burst
    wr(2'd3, 32'h0);
    chk(irq == 1'b0, "R10 error cleared", irq, 0);
    wr(2'd0, 32'hC00); wr(2'd1, 32'hD00); wr(2'd2, 32'h3);
    predict(32'hC00, 32'hD00, 3'b011, 3'b011, 1'b1, 3, 3, 1'b0, 1'b0);
    wr_acks = 0;
    wr(2'd3, 32'h3309);
    wait (wr_acks == 2);
    reg_idx = 2'd3; reg_wdata = 32'h3308; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0, "R11 stops after beat in progress", exp_q.size(), 0);
    rd(2'd3, v); chk(v == 32'h3308, "R11 no finish on abort", v, 32'h3308);
    rd(2'd2, v); chk(v == 3, "R11 count kept", v, 3);
    rd(2'd0, v); chk(v == 32'hC0C, "R11 source after three beats", v, 32'hC0C);
    rd(2'd1, v); chk(v == 32'hD0C, "R11 destination after three beats", v, 32'hD0C);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule